// File: doc/BRIEF.md
# Multi-View FIFO Synchronization Cell

This block is a single storage cell that hardware threads use to hand data words to one another through a small first-in first-out queue. Each access carries a view code that selects how the cell responds. One view inspects or patches the queue contents without moving any pointer. One view reads or rewrites the status tag. Two views pop (read) or push (write) the queue: one of them blocks and one does not. The surrounding logic decodes addresses into a view code and schedules threads. The cell itself only answers each request in the cycle it is presented.

A blocking pop while the tag's empty flag is set, or a blocking push while its full flag is set, has no effect on the queue. It answers with a stall response and records the requesting thread in a blocked-thread mask. The next empty/full access that does not stall drives that mask onto a wake vector for one cycle and clears it, so that the scheduler can retry the parked threads. Responses (read data, stall, error, wake) are combinational in the request cycle. All state updates at the following rising clock edge.

Top module: `tsync_cell`

## Requirements
- R1: After reset the queue holds no entries, both pointers and all storage are zero, the T and full flags are 0, the empty flag is 1, the FIFO-mode flag is 1 and the depth field holds log2(DEPTH). With the default DEPTH of 4, a tag read returns 32'h2002_0001.
- R2: A read with view code 1 returns the tag with these fields: log2(DEPTH) in bits [31:28], entry count in bits [27:18], FIFO-mode in bit 17, T in bit 16, full in bit 1, empty in bit 0, and zero in all other bits.
- R3: A write with view code 1 copies data bit 16 into T, bit 1 into full and bit 0 into empty. It leaves the count, the pointers, the storage and the depth and mode fields unchanged.
- R4: A read with view code 0 returns the storage word at the output pointer, even when the count is zero, and changes no state.
- R5: A write with view code 0 and a nonzero count overwrites the newest entry, at (out + count - 1) mod DEPTH, and moves no pointer. With a count of zero it is ignored.
- R6: A push that proceeds with count < DEPTH stores the word at (out + count) mod DEPTH, increments the count and clears empty. Full is set when the count reaches DEPTH.
- R7: A pop that proceeds with a nonzero count returns the word at the output pointer, advances the pointer, decrements the count and clears full. Empty is set when the count reaches zero.
- R8: View code 2 is the blocking empty/full view. A read there while empty is set, or a write there while full is set, raises rsp_stall and returns zero. It sets the requester's bit in the blocked mask and changes nothing else. The flags decide the stall, not the count.
- R9: Any view 2 or view 3 access that does not stall drives the blocked mask onto wake_vec in its own cycle and clears the mask at the next edge.
- R10: View code 3 is the non-blocking empty/full view. It never stalls. A pop there with a count of zero returns zero, and a push there with a full count drops the data. Neither changes the queue.
- R11: View codes 4 to 7 return zero and raise rsp_err. They change no state and do not wake any thread.
- R12: Both pointers wrap modulo DEPTH, so data stays in order across the end of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View code: 0 bypass, 1 tag, 2 blocking empty/full, 3 non-blocking empty/full |
| req_thread | input | TID_W (2) | Requesting thread number |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, valid in the request cycle |
| rsp_stall | output | 1 | Blocking access could not proceed |
| rsp_err | output | 1 | Undefined view code |
| wake_vec | output | NTHR (4) | One-cycle pulse of the threads to wake |

## Verification
A wrong pointer or count shows first on a tag read, because the count field is exposed directly. It also shows within one pop, when words come out in the wrong order or a patched word lands on the wrong entry. A flag that disagrees with the count shows as a stall on the next blocking access, or as the absence of one. A blocked mask that is lost or never cleared shows on wake_vec at the very next non-stalled empty/full access, either as a missing bit or as a repeated pulse.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // view codes seen at the port
  localparam logic [2:0] VIEW_BYPASS = 3'd0;
  localparam logic [2:0] VIEW_TAG    = 3'd1;
  localparam logic [2:0] VIEW_EF_BLK = 3'd2;
  localparam logic [2:0] VIEW_EF_NB  = 3'd3;

  // tag bit positions (software decodes these)
  localparam int TAG_DEPTH_LSB = 28;
  localparam int TAG_COUNT_LSB = 18;
  localparam int TAG_MODE_BIT  = 17;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_EMPTY_BIT = 0;

  typedef enum logic [2:0] {
    OP_NONE, OP_BYP_RD, OP_BYP_WR, OP_TAG_RD, OP_TAG_WR, OP_POP, OP_PUSH, OP_BAD
  } cell_op_e;

  // ring arithmetic on the storage index
  function automatic int unsigned ring_idx(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction

  // tag image, 32 bits
  function automatic logic [31:0] tag_pack(int unsigned depth_log, int unsigned cnt,
                                           logic t, logic f, logic e);
    logic [31:0] v;
    v = '0;
    v[31:TAG_DEPTH_LSB]    = 4'(depth_log);
    v[27:TAG_COUNT_LSB]    = 10'(cnt);
    v[TAG_MODE_BIT]        = 1'b1;
    v[TAG_T_BIT]           = t;
    v[TAG_FULL_BIT]        = f;
    v[TAG_EMPTY_BIT]       = e;
    return v;
  endfunction

endpackage

// File: rtl/tsc_view_dec.sv
module tsc_view_dec
  import tsc_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [2:0] view,
  output cell_op_e   op,
  output logic       blocking
);
  always_comb begin
    op       = OP_NONE;
    blocking = 1'b0;
    if (valid) begin
      unique case (view)
        VIEW_BYPASS: op = write ? OP_BYP_WR : OP_BYP_RD;
        VIEW_TAG:    op = write ? OP_TAG_WR : OP_TAG_RD;
        VIEW_EF_BLK: begin
          op       = write ? OP_PUSH : OP_POP;
          blocking = 1'b1;
        end
        VIEW_EF_NB:  op = write ? OP_PUSH : OP_POP;
        default:     op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/tsc_store.sv
module tsc_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PTR_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             slot[g] <= '0;
      else if (we && (widx == PTR_W'(g)))     slot[g] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NTHR  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cell_op_e         op,
  input  logic             blocking,
  input  logic [TID_W-1:0] tid,
  input  logic             wr_t,
  input  logic             wr_f,
  input  logic             wr_e,
  output logic             stall,
  output logic             ef_go,
  output logic             do_pop,
  output logic             do_push,
  output logic             do_patch,
  output logic [NTHR-1:0]  wake_vec,
  output logic [NTHR-1:0]  mask,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] out_ptr,
  output logic             flag_t,
  output logic             flag_f,
  output logic             flag_e,
  output logic             st_we,
  output logic [PTR_W-1:0] st_widx
);
  logic is_ef;
  logic do_tagwr;

  assign is_ef    = (op == OP_POP) || (op == OP_PUSH);
  assign stall    = blocking && (((op == OP_POP) && flag_e) || ((op == OP_PUSH) && flag_f));
  assign ef_go    = is_ef && !stall;
  assign do_pop   = ef_go && (op == OP_POP)  && (count != '0);
  assign do_push  = ef_go && (op == OP_PUSH) && (count < CNT_W'(DEPTH));
  assign do_patch = (op == OP_BYP_WR) && (count != '0);
  assign do_tagwr = (op == OP_TAG_WR);
  assign wake_vec = ef_go ? mask : '0;

  assign st_we   = do_push || do_patch;
  assign st_widx = do_push ? PTR_W'(ring_idx(out_ptr, count, DEPTH))
                           : PTR_W'(ring_idx(out_ptr, count + DEPTH - 1, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      out_ptr <= '0;
      flag_t  <= 1'b0;
      flag_f  <= 1'b0;
      flag_e  <= 1'b1;
    end else begin
      if (do_pop) begin
        out_ptr <= PTR_W'(ring_idx(out_ptr, 1, DEPTH));
        count   <= count - CNT_W'(1);
        flag_f  <= 1'b0;
        if (count == CNT_W'(1)) flag_e <= 1'b1;
      end
      if (do_push) begin
        count  <= count + CNT_W'(1);
        flag_e <= 1'b0;
        if (count == CNT_W'(DEPTH - 1)) flag_f <= 1'b1;
      end
      if (do_tagwr) begin
        flag_t <= wr_t;
        flag_f <= wr_f;
        flag_e <= wr_e;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     mask <= '0;
    else if (stall) mask <= mask | (NTHR'(1) << tid);
    else if (ef_go) mask <= '0;
  end
endmodule

// File: rtl/tsync_cell.sv
module tsync_cell
  import tsc_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int NTHR   = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int DLOG  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [2:0]        req_view,
  input  logic [TID_W-1:0]  req_thread,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_stall,
  output logic              rsp_err,
  output logic [NTHR-1:0]   wake_vec
);
  cell_op_e          op;
  logic              blocking;
  logic              ef_go, do_pop, do_push, do_patch;
  logic [NTHR-1:0]   mask;
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  out_ptr;
  logic              flag_t, flag_f, flag_e;
  logic              st_we;
  logic [PTR_W-1:0]  st_widx;
  logic [DATA_W-1:0] head_word;
  logic [31:0]       tag_word;

  tsc_view_dec u_dec (
    .valid    (req_valid),
    .write    (req_write),
    .view     (req_view),
    .op       (op),
    .blocking (blocking)
  );

  tsc_ctrl #(.DEPTH(DEPTH), .NTHR(NTHR)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .blocking (blocking),
    .tid      (req_thread),
    .wr_t     (req_wdata[TAG_T_BIT]),
    .wr_f     (req_wdata[TAG_FULL_BIT]),
    .wr_e     (req_wdata[TAG_EMPTY_BIT]),
    .stall    (rsp_stall),
    .ef_go    (ef_go),
    .do_pop   (do_pop),
    .do_push  (do_push),
    .do_patch (do_patch),
    .wake_vec (wake_vec),
    .mask     (mask),
    .count    (count),
    .out_ptr  (out_ptr),
    .flag_t   (flag_t),
    .flag_f   (flag_f),
    .flag_e   (flag_e),
    .st_we    (st_we),
    .st_widx  (st_widx)
  );

  tsc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .widx  (st_widx),
    .wdata (req_wdata),
    .ridx  (out_ptr),
    .rdata (head_word)
  );

  assign tag_word = tag_pack(DLOG, count, flag_t, flag_f, flag_e);
  assign rsp_err  = (op == OP_BAD);

  always_comb begin
    rsp_rdata = '0;
    unique case (op)
      OP_BYP_RD: rsp_rdata = head_word;
      OP_TAG_RD: rsp_rdata = DATA_W'(tag_word);
      OP_POP:    if (do_pop) rsp_rdata = head_word;
      default:   rsp_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
  parameter int DEPTH = 4,
  parameter int DATA_W = 32,
  parameter int NTHR  = 4,
  parameter int CNT_W = 3,
  parameter int TID_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TID_W-1:0]  tid,
  input logic              stall,
  input logic              err,
  input logic [DATA_W-1:0] rdata,
  input logic [NTHR-1:0]   wake_vec,
  input logic [NTHR-1:0]   mask,
  input logic [CNT_W-1:0]  count,
  input logic              do_pop,
  input logic              do_push,
  input logic              flag_e
);
  p_count_le_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_push_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> count == $past(count) + CNT_W'(1));
  p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> count == $past(count) - CNT_W'(1));
  p_pop_to_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && count == CNT_W'(1)) |=> flag_e);
  p_stall_records_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> mask[$past(tid)]);
  p_stall_keeps_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(count));
  p_wake_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wake_vec) |=> mask == '0);
  p_err_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rdata == '0 && !stall && wake_vec == '0));
endmodule

bind tsync_cell tsc_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .NTHR(NTHR), .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tid      (req_thread),
  .stall    (rsp_stall),
  .err      (rsp_err),
  .rdata    (rsp_rdata),
  .wake_vec (wake_vec),
  .mask     (mask),
  .count    (count),
  .do_pop   (do_pop),
  .do_push  (do_push),
  .flag_e   (flag_e)
);

// File: tb/sim_tsync_cell.sv
`timescale 1ns/1ps
module sim_tsync_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_view = '0;
  logic [1:0]  req_thread = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_stall, rsp_err;
  logic [3:0]  wake_vec;

  logic [31:0] r_data;
  logic        r_stall, r_err;
  logic [3:0]  r_wake;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tsync_cell u0 (.*);

  // expected tag for DEPTH 4 (depth field 2)
  function automatic logic [31:0] etag(int cnt, bit t, bit f, bit e);
    return (32'd2 << 28) | (32'(cnt) << 18) | (32'd1 << 17) |
           (32'(t) << 16) | (32'(f) << 1) | 32'(e);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(bit wr, logic [2:0] vw, logic [1:0] tid, logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_view = vw; req_thread = tid; req_wdata = wd;
    #1;
    r_data = rsp_rdata; r_stall = rsp_stall; r_err = rsp_err; r_wake = wake_vec;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic tag_is(string req, logic [31:0] exp);
    acc(0, 3'd1, 0, 0);
    check(req, r_data, exp);
  endtask

  task automatic t_reset();
    tag_is("R1 reset tag", 32'h2002_0001);
    check("R2 reset no wake", {28'd0, r_wake}, 32'd0);
  endtask

  task automatic t_fifo();
    acc(1, 3'd3, 0, 32'h11);
    check("R6 push no stall", {31'd0, r_stall}, 0);
    tag_is("R6 count1 empty cleared", etag(1, 0, 0, 0));
    acc(1, 3'd3, 0, 32'h22);
    acc(1, 3'd3, 0, 32'h33);
    acc(1, 3'd3, 0, 32'h44);
    tag_is("R6 full at depth", etag(4, 0, 1, 0));
    acc(0, 3'd0, 0, 0);
    check("R4 bypass read head", r_data, 32'h11);
    tag_is("R4 bypass read no pop", etag(4, 0, 1, 0));
    acc(1, 3'd0, 0, 32'h55);
    acc(1, 3'd3, 0, 32'h66);
    check("R10 try push full no stall", {31'd0, r_stall}, 0);
    tag_is("R10 try push full dropped", etag(4, 0, 1, 0));
    acc(0, 3'd2, 0, 0);
    check("R7 pop oldest", r_data, 32'h11);
    tag_is("R7 pop clears full", etag(3, 0, 0, 0));
    acc(0, 3'd2, 0, 0); check("R7 pop order", r_data, 32'h22);
    acc(0, 3'd2, 0, 0); check("R7 pop order", r_data, 32'h33);
    acc(0, 3'd2, 0, 0); check("R5 patched newest", r_data, 32'h55);
    tag_is("R7 empty at zero", etag(0, 0, 0, 1));
    acc(0, 3'd3, 0, 0);
    check("R10 try pop empty zero", r_data, 0);
    check("R10 try pop empty no stall", {31'd0, r_stall}, 0);
    acc(0, 3'd0, 0, 0);
    check("R4 bypass read stale head", r_data, 32'h11);
    acc(1, 3'd0, 0, 32'h77);
    acc(0, 3'd0, 0, 0);
    check("R5 patch ignored at zero count", r_data, 32'h11);
    tag_is("R5 patch no state", etag(0, 0, 0, 1));
  endtask

  task automatic t_wrap();
    acc(1, 3'd3, 0, 32'h101);
    acc(1, 3'd3, 0, 32'h102);
    acc(1, 3'd3, 0, 32'h103);
    acc(0, 3'd3, 0, 0); check("R12 wrap pop", r_data, 32'h101);
    acc(1, 3'd3, 0, 32'h104);
    acc(1, 3'd3, 0, 32'h105);
    tag_is("R12 full after wrap", etag(4, 0, 1, 0));
    for (int i = 2; i <= 5; i++) begin
      acc(0, 3'd3, 0, 0);
      check("R12 wrap order", r_data, 32'h100 + 32'(i));
    end
  endtask

  task automatic t_stall();
    acc(0, 3'd2, 2'd1, 0);
    check("R8 blocking pop empty stalls", {31'd0, r_stall}, 1);
    check("R8 stall data zero", r_data, 0);
    acc(0, 3'd2, 2'd3, 0);
    check("R8 second stall", {31'd0, r_stall}, 1);
    tag_is("R8 stall no state change", etag(0, 0, 0, 1));
    acc(1, 3'd2, 2'd0, 32'hAA);
    check("R9 push no stall", {31'd0, r_stall}, 0);
    check("R9 wake recorded threads", {28'd0, r_wake}, 32'hA);
    acc(0, 3'd3, 0, 0);
    check("R9 pop data", r_data, 32'hAA);
    check("R9 mask cleared", {28'd0, r_wake}, 0);
    acc(1, 3'd3, 0, 32'd1);
    acc(1, 3'd3, 0, 32'd2);
    acc(1, 3'd3, 0, 32'd3);
    acc(1, 3'd1, 0, 32'hFFFF_FFFE);
    tag_is("R3 tag write flags only", etag(3, 1, 1, 0));
    acc(1, 3'd2, 2'd2, 32'h99);
    check("R8 stall on full flag", {31'd0, r_stall}, 1);
    tag_is("R8 flag stall no push", etag(3, 1, 1, 0));
    acc(0, 3'd3, 0, 0);
    check("R9 try pop data", r_data, 32'd1);
    check("R9 try pop wakes", {28'd0, r_wake}, 32'h4);
    tag_is("R7 pop clears full keeps T", etag(2, 1, 0, 0));
    acc(1, 3'd1, 0, 32'h0);
    tag_is("R3 tag write clears", etag(2, 0, 0, 0));
    acc(0, 3'd3, 0, 0); check("R7 drain", r_data, 32'd2);
    acc(0, 3'd3, 0, 0); check("R7 drain", r_data, 32'd3);
  endtask

  task automatic t_undef();
    acc(0, 3'd2, 2'd1, 0);
    acc(0, 3'd5, 0, 0);
    check("R11 undefined read zero", r_data, 0);
    check("R11 undefined err", {31'd0, r_err}, 1);
    acc(1, 3'd7, 2'd0, 32'hFFFF_FFFF);
    check("R11 undefined write err", {31'd0, r_err}, 1);
    check("R11 undefined no wake", {28'd0, r_wake}, 0);
    tag_is("R11 no state change", etag(0, 0, 0, 1));
    acc(0, 3'd3, 0, 0);
    check("R11 mask survived undefined", {28'd0, r_wake}, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fifo();
    t_wrap();
    t_stall();
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule